// File: doc/BRIEF.md
# Register-Operand Execute Unit with Half-Word Immediate Merge

This block is the execute stage of a 32-bit register machine. Each cycle it can take one operation: an operation code, two source operand values, the value the destination register holds now, and a 16-bit immediate. It returns a 32-bit result together with a write-enable for the register file. Results leave through a single output register, so each one appears one clock after its inputs are sampled.

The unit covers wrapping add and subtract, increment and decrement of the destination, logical left and right shifts, the seven bitwise logic functions, plain and sign-extending moves, and two immediate loads. Each immediate load replaces one half of the destination and keeps the other half. Two behaviours depend on the destination's current value. A shift takes its amount from the destination when that value is nonzero, and from the immediate otherwise. The sign-extending move chooses its sign bit from the size of the source value.

Top module: `xu_exec`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `res_we` is 0 and `res_data` is 0.
- R2: `op` is 5 bits. The codes are 0 none, 1 move, 2 signed move, 3 add, 4 subtract, 5 increment, 6 decrement, 7 shift left, 8 shift right, 9 AND, 10 OR, 11 NOT, 12 XOR, 13 NAND, 14 NOR, 15 XNOR, 16 load lower immediate and 17 load upper immediate. When `in_valid` is high with a code from 1 to 17, `res_we` is 1 one clock later and `res_data` holds that operation's result.
- R3: When `in_valid` is low, or `op` is 0, or `op` is from 18 to 31, `res_we` is 0 one clock later and `res_data` keeps its previous value.
- R4: Add gives `src_a + src_b` and subtract gives `src_a - src_b`, both modulo 2^32.
- R5: Increment gives `dst_cur + 1` and decrement gives `dst_cur - 1`, both modulo 2^32.
- R6: AND, OR and XOR combine `src_a` with `src_b` bit by bit. NAND, NOR and XNOR give the bitwise complements of those three. NOT gives the complement of `src_a`.
- R7: A shift moves `src_a`. Its amount is `dst_cur[7:0]` when `dst_cur` is nonzero, and `imm[7:0]` when `dst_cur` is zero. A nonzero `dst_cur` whose low byte is zero therefore gives an amount of 0.
- R8: Both shifts fill vacated bits with zeros. An amount of 32 or more gives a result of 0.
- R9: Move gives `src_a`. Signed move gives the following: for `src_a` at most 0xFF, `src_a` sign-extended from bit 7; for `src_a` at most 0xFFFF, `src_a` sign-extended from bit 15; for any larger value, `src_a` unchanged.
- R10: Load lower immediate gives `{dst_cur[31:16], imm}`.
- R11: Load upper immediate gives `{imm, dst_cur[15:0]}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is present this cycle |
| op | input | 5 | Operation code (encoding in R2) |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| dst_cur | input | 32 | Current value of the destination register |
| imm | input | 16 | Immediate field |
| res_we | output | 1 | Destination write-enable, registered |
| res_data | output | 32 | Result value, registered |

## Verification
Every result of this block is due exactly one clock after the edge that samples its operands, whatever the operation. No operation takes longer. The bench drives each operation on a falling edge. It computes the expected write-enable and value from its own model of the requirements. It compares them at the next falling edge, half a period after the capturing rising edge. The model also carries the held value, so cycles that must leave `res_data` unchanged are compared against the last value actually written.

// File: rtl/xu_pkg.sv
package xu_pkg;

    localparam int unsigned XU_OP_W = 5;

    typedef enum logic [XU_OP_W-1:0] {
        XOP_NONE  = 5'd0,
        XOP_MOV   = 5'd1,
        XOP_MOVSX = 5'd2,
        XOP_ADD   = 5'd3,
        XOP_SUB   = 5'd4,
        XOP_INC   = 5'd5,
        XOP_DEC   = 5'd6,
        XOP_SHL   = 5'd7,
        XOP_SHR   = 5'd8,
        XOP_AND   = 5'd9,
        XOP_OR    = 5'd10,
        XOP_NOT   = 5'd11,
        XOP_XOR   = 5'd12,
        XOP_NAND  = 5'd13,
        XOP_NOR   = 5'd14,
        XOP_XNOR  = 5'd15,
        XOP_LDLO  = 5'd16,
        XOP_LDHI  = 5'd17
    } xu_op_e;

    typedef enum logic [2:0] {
        GRP_NONE,
        GRP_ARITH,
        GRP_LOGIC,
        GRP_SHIFT,
        GRP_MOVE
    } xu_grp_e;

    typedef struct packed {
        xu_grp_e grp;
        logic    writes;
    } xu_dec_t;

    function automatic xu_dec_t xu_decode(input logic [XU_OP_W-1:0] code);
        xu_dec_t d;
        d.writes = 1'b1;
        case (code)
            XOP_ADD, XOP_SUB, XOP_INC, XOP_DEC:              d.grp = GRP_ARITH;
            XOP_AND, XOP_OR, XOP_NOT, XOP_XOR,
            XOP_NAND, XOP_NOR, XOP_XNOR:                     d.grp = GRP_LOGIC;
            XOP_SHL, XOP_SHR:                                d.grp = GRP_SHIFT;
            XOP_MOV, XOP_MOVSX, XOP_LDLO, XOP_LDHI:          d.grp = GRP_MOVE;
            default: begin
                d.grp    = GRP_NONE;
                d.writes = 1'b0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/xu_arith.sv
module xu_arith
    import xu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  xu_op_e            op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] y
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;
    logic              subtract;

    // Increment and decrement reuse the adder with the destination as left operand.
    always_comb begin
        lhs      = a;
        rhs      = b;
        subtract = 1'b0;
        case (op)
            XOP_SUB: subtract = 1'b1;
            XOP_INC: begin lhs = d; rhs = ONE; end
            XOP_DEC: begin lhs = d; rhs = ONE; subtract = 1'b1; end
            default: ;
        endcase
        y = subtract ? (lhs - rhs) : (lhs + rhs);
    end
endmodule

// File: rtl/xu_logic.sv
module xu_logic
    import xu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  xu_op_e            op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [1:0] fsel;   // 0 and, 1 or, 2 xor, 3 pass a
    logic       inv;

    always_comb begin
        fsel = 2'd0;
        inv  = 1'b0;
        case (op)
            XOP_AND:  begin fsel = 2'd0; end
            XOP_OR:   begin fsel = 2'd1; end
            XOP_XOR:  begin fsel = 2'd2; end
            XOP_NAND: begin fsel = 2'd0; inv = 1'b1; end
            XOP_NOR:  begin fsel = 2'd1; inv = 1'b1; end
            XOP_XNOR: begin fsel = 2'd2; inv = 1'b1; end
            XOP_NOT:  begin fsel = 2'd3; inv = 1'b1; end
            default:  ;
        endcase
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic base;
        always_comb begin
            case (fsel)
                2'd0:    base = a[i] & b[i];
                2'd1:    base = a[i] | b[i];
                2'd2:    base = a[i] ^ b[i];
                default: base = a[i];
            endcase
        end
        assign y[i] = base ^ inv;
    end
endmodule

// File: rtl/xu_shift.sv
module xu_shift
    import xu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned AMT_W  = 8
) (
    input  xu_op_e            op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] d,
    input  logic [AMT_W-1:0]  imm_amt,
    output logic [DATA_W-1:0] y
);
    localparam int unsigned CMP_W = (AMT_W > 32) ? AMT_W : 32;

    logic [AMT_W-1:0] amt;
    logic [CMP_W-1:0] amt_ext;
    logic             overflow;

    // A nonzero destination supplies the amount; otherwise the immediate does.
    assign amt      = (d != '0) ? d[AMT_W-1:0] : imm_amt;
    assign amt_ext  = CMP_W'(amt);
    assign overflow = (amt_ext >= CMP_W'(DATA_W));

    always_comb begin
        if (overflow)
            y = '0;
        else if (op == XOP_SHR)
            y = a >> amt;
        else
            y = a << amt;
    end
endmodule

// File: rtl/xu_move.sv
module xu_move
    import xu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned BYTE_W = 8
) (
    input  xu_op_e            op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] d,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] y
);
    localparam int unsigned KEEP_W = DATA_W - IMM_W;

    logic              fits_byte;
    logic              fits_half;
    logic [DATA_W-1:0] sx_byte;
    logic [DATA_W-1:0] sx_half;
    logic [DATA_W-1:0] sx_val;

    assign fits_byte = (a >> BYTE_W) == '0;
    assign fits_half = (a >> IMM_W) == '0;
    assign sx_byte   = {{(DATA_W-BYTE_W){a[BYTE_W-1]}}, a[BYTE_W-1:0]};
    assign sx_half   = {{(DATA_W-IMM_W){a[IMM_W-1]}}, a[IMM_W-1:0]};
    assign sx_val    = fits_byte ? sx_byte : (fits_half ? sx_half : a);

    always_comb begin
        case (op)
            XOP_MOVSX: y = sx_val;
            XOP_LDLO:  y = {d[DATA_W-1:IMM_W], imm};
            XOP_LDHI:  y = {imm, d[KEEP_W-1:0]};
            default:   y = a;
        endcase
    end
endmodule

// File: rtl/xu_exec.sv
module xu_exec
    import xu_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned AMT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [4:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [DATA_W-1:0] dst_cur,
    input  logic [IMM_W-1:0]  imm,
    output logic              res_we,
    output logic [DATA_W-1:0] res_data
);
    xu_op_e            op_e;
    xu_dec_t           dec;
    logic [DATA_W-1:0] y_arith;
    logic [DATA_W-1:0] y_logic;
    logic [DATA_W-1:0] y_shift;
    logic [DATA_W-1:0] y_move;
    logic [DATA_W-1:0] y_sel;

    assign op_e = xu_op_e'(op);
    assign dec  = xu_decode(op);

    xu_arith #(.DATA_W(DATA_W)) u_arith (
        .op(op_e), .a(src_a), .b(src_b), .d(dst_cur), .y(y_arith)
    );

    xu_logic #(.DATA_W(DATA_W)) u_logic (
        .op(op_e), .a(src_a), .b(src_b), .y(y_logic)
    );

    xu_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
        .op(op_e), .a(src_a), .d(dst_cur), .imm_amt(imm[AMT_W-1:0]), .y(y_shift)
    );

    xu_move #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_move (
        .op(op_e), .a(src_a), .d(dst_cur), .imm(imm), .y(y_move)
    );

    always_comb begin
        case (dec.grp)
            GRP_ARITH: y_sel = y_arith;
            GRP_LOGIC: y_sel = y_logic;
            GRP_SHIFT: y_sel = y_shift;
            default:   y_sel = y_move;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_we   <= 1'b0;
            res_data <= '0;
        end else begin
            res_we <= in_valid && dec.writes;
            if (in_valid && dec.writes)
                res_data <= y_sel;
        end
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_we && $stable(res_data)));

    // R3
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 5'd0 || op > 5'd17)) |=> !res_we);

    // R5
    inc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 5'd5) |=> (res_we && res_data == $past(dst_cur) + 1'b1));

    // R10
    lo_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 5'd16) |=>
            (res_data[DATA_W-1:IMM_W] == $past(dst_cur[DATA_W-1:IMM_W]) &&
             res_data[IMM_W-1:0] == $past(imm)));

    // R11
    hi_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 5'd17) |=>
            (res_data[IMM_W-1:0] == $past(dst_cur[IMM_W-1:0]) &&
             res_data[DATA_W-1:IMM_W] == $past(imm)));

    // R8
    shift_big_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (op == 5'd7 || op == 5'd8) && dst_cur == '0 &&
         imm[AMT_W-1:0] >= AMT_W'(DATA_W)) |=> (res_data == '0));
endmodule

// File: tb/xu_exec_bench.sv
module xu_exec_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [4:0]  op;
    logic [31:0] src_a, src_b, dst_cur;
    logic [15:0] imm;
    logic        res_we;
    logic [31:0] res_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [31:0] model_data = 32'h0;

    always #2.5 clk = ~clk;

    xu_exec u_xu_exec (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b), .dst_cur(dst_cur), .imm(imm),
        .res_we(res_we), .res_data(res_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish (got %0d cycles, expected under 20000)", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [31:0] ref_result(int code, logic [31:0] a, logic [31:0] b,
                                               logic [31:0] d, logic [15:0] k);
        longint unsigned sh;
        case (code)
            1:  return a;
            2: begin
                if (a <= 32'd255)        return (a[7]  ? (a | 32'hFFFF_FF00) : a);
                else if (a <= 32'd65535) return (a[15] ? (a | 32'hFFFF_0000) : a);
                else                     return a;
            end
            3:  return a + b;
            4:  return a - b;
            5:  return d + 32'd1;
            6:  return d - 32'd1;
            7, 8: begin
                sh = (d != 0) ? longint'(d % 256) : longint'(k % 256);
                if (sh >= 32) return 32'h0;
                return (code == 7) ? (a << sh) : (a >> sh);
            end
            9:  return a & b;
            10: return a | b;
            11: return ~a;
            12: return a ^ b;
            13: return ~(a & b);
            14: return ~(a | b);
            15: return ~(a ^ b);
            16: return (d & 32'hFFFF_0000) | {16'h0, k};
            17: return (d & 32'h0000_FFFF) | ({16'h0, k} << 16);
            default: return 32'h0;
        endcase
    endfunction

    // Drive on a falling edge, compare at the next falling edge (one register of latency).
    task automatic run_op(input string req, input logic v, input int code,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] d, input logic [15:0] k);
        logic exp_we;
        in_valid = v;
        op       = 5'(code);
        src_a    = a;
        src_b    = b;
        dst_cur  = d;
        imm      = k;
        exp_we   = v && code >= 1 && code <= 17;
        if (exp_we) model_data = ref_result(code, a, b, d, k);
        @(negedge clk);
        checks++;
        if (res_we !== exp_we || res_data !== model_data) begin
            fails++;
            $display("FAIL %s op=%0d: got we=%0b data=%08h, expected we=%0b data=%08h",
                     req, code, res_we, res_data, exp_we, model_data);
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = 5'd0;
        src_a = '0; src_b = '0; dst_cur = '0; imm = '0;
        @(negedge clk); @(negedge clk);
        // R1 during reset
        checks++;
        if (res_we !== 1'b0 || res_data !== 32'h0) begin
            fails++;
            $display("FAIL R1 reset: got we=%0b data=%08h, expected we=0 data=00000000", res_we, res_data);
        end
        rst = 1'b0;
        run_op("R1", 1'b0, 3, 32'h5, 32'h6, 32'h0, 16'h0);

        // R2, R4 add/sub with wrap
        run_op("R4", 1'b1, 3, 32'h0000_1234, 32'h0000_0111, 32'h0, 16'h0);
        run_op("R4", 1'b1, 3, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 16'h0);
        run_op("R4", 1'b1, 4, 32'h0000_0000, 32'h0000_0001, 32'h0, 16'h0);
        run_op("R4", 1'b1, 4, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 16'h0);

        // R5 increment and decrement act on the destination
        run_op("R5", 1'b1, 5, 32'h1111_1111, 32'h0, 32'hFFFF_FFFF, 16'h0);
        run_op("R5", 1'b1, 6, 32'h1111_1111, 32'h0, 32'h0000_0000, 16'h0);
        run_op("R5", 1'b1, 5, 32'h0, 32'h0, 32'h0000_00FF, 16'h0);

        // R6 logic family
        for (int c = 9; c <= 15; c++)
            run_op("R6", 1'b1, c, 32'hF0F0_3C3C, 32'hFF00_5A5A, 32'h0, 16'h0);

        // R7 amount source selection, R8 zero fill and overflow
        run_op("R7", 1'b1, 7, 32'h0000_0001, 32'h0, 32'h0000_0000, 16'h0004);
        run_op("R7", 1'b1, 7, 32'h0000_0001, 32'h0, 32'h0000_0003, 16'h0010);
        run_op("R7", 1'b1, 8, 32'hDEAD_BEEF, 32'h0, 32'h0000_0100, 16'h0008);
        run_op("R7", 1'b1, 8, 32'h0000_F000, 32'h0, 32'h0000_0000, 16'hAB0C);
        run_op("R8", 1'b1, 8, 32'h8000_0000, 32'h0, 32'h0000_0004, 16'h0000);
        run_op("R8", 1'b1, 7, 32'hFFFF_FFFF, 32'h0, 32'h0000_001F, 16'h0000);
        run_op("R8", 1'b1, 7, 32'hFFFF_FFFF, 32'h0, 32'h0000_0000, 16'h0020);
        run_op("R8", 1'b1, 8, 32'hFFFF_FFFF, 32'h0, 32'h0000_0028, 16'h0000);
        run_op("R8", 1'b1, 8, 32'hFFFF_FFFF, 32'h0, 32'h0000_0000, 16'h00FF);

        // R9 moves
        run_op("R9", 1'b1, 1, 32'h89AB_CDEF, 32'h0, 32'h0, 16'h0);
        run_op("R9", 1'b1, 2, 32'h0000_0080, 32'h0, 32'h0, 16'h0);
        run_op("R9", 1'b1, 2, 32'h0000_007F, 32'h0, 32'h0, 16'h0);
        run_op("R9", 1'b1, 2, 32'h0000_8000, 32'h0, 32'h0, 16'h0);
        run_op("R9", 1'b1, 2, 32'h0000_7F80, 32'h0, 32'h0, 16'h0);
        run_op("R9", 1'b1, 2, 32'h0001_8000, 32'h0, 32'h0, 16'h0);
        run_op("R9", 1'b1, 2, 32'hFFFF_FFFF, 32'h0, 32'h0, 16'h0);

        // R10, R11 immediate merges
        run_op("R10", 1'b1, 16, 32'h0, 32'h0, 32'hCAFE_1234, 16'hBEEF);
        run_op("R11", 1'b1, 17, 32'h0, 32'h0, 32'hCAFE_1234, 16'hBEEF);
        run_op("R11", 1'b1, 17, 32'h0, 32'h0, 32'h0000_0000, 16'h8001);

        // R3 no write: idle, code 0, unused codes; data must hold
        run_op("R3", 1'b1, 3, 32'h0000_00AA, 32'h0000_0055, 32'h0, 16'h0);
        run_op("R3", 1'b0, 3, 32'h1000_0000, 32'h2000_0000, 32'h0, 16'h0);
        run_op("R3", 1'b1, 0, 32'h1000_0000, 32'h2000_0000, 32'h0, 16'h0);
        run_op("R3", 1'b1, 18, 32'h1000_0000, 32'h2000_0000, 32'h0, 16'h0);
        run_op("R3", 1'b1, 31, 32'h1000_0000, 32'h2000_0000, 32'h0, 16'h0);

        // R2 back-to-back writes, one per cycle
        for (int i = 0; i < 8; i++)
            run_op("R2", 1'b1, 3 + (i % 2), 32'(i * 32'h0101_0101), 32'(i + 7), 32'h0, 16'h0);

        run_op("R3", 1'b0, 0, 32'h0, 32'h0, 32'h0, 16'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule